// File: doc/BRIEF.md
# Sideband request/reply mailbox

This block sits between the sideband channel logic of a display-link sink and a host processor. The link side delivers one request message as a stream of bytes. The first byte is the command and the bytes after it are the data. The block keeps the message in a receive buffer and records its total length. It then raises a ready flag, and an interrupt if the host has enabled one. The host reads the length, the data bytes and the command through a small word-wide register bus. Reading the command register frees the buffer for the next request.

For a reply, the host fills a separate command register and a 16-byte transmit buffer. It then writes the total length and a start strobe in one register write. The block sends the command byte and then the data bytes on a valid/ready byte stream, and marks the final byte. A transmitter-idle flag tells the host when a new reply may be started.

Register map (word addresses): 0x00 status/enable, 0x01 transmit control (write only), 0x02 received command (read clears), 0x03 reply command, 0x10+i received data byte i, 0x20+i reply data byte i. Status bits: bit 0 message ready, bit 1 transmitter idle, bit 2 overrun (write 1 to clear), bit 3 bad-length error (write 1 to clear), bit 4 interrupt enable (read/write), bits 12:8 received length. Transmit control: bits 7:0 length, bit 8 start strobe.

Top module: `sb_mailbox`

## Requirements
- R1: After reset the status word reads 0x00000002: idle 1, every other bit 0. The irq and tx_valid outputs are also 0.
- R2: rx_ready is held at 1. When a byte with rx_last arrives, status bit 0 becomes 1 and bits 12:8 hold the number of bytes in the message (command plus data). The count is capped at 17, and bytes after the 17th are discarded.
- R3: Address 0x02 returns the first byte of the captured request. Address 0x10+i returns data byte i (the byte that arrived at position i+1).
- R4: A host read of address 0x02 clears status bit 0 and status bits 12:8 from the next cycle on.
- R5: irq is 1 exactly when status bit 4 (interrupt enable) and status bit 0 are both 1.
- R6: A request whose first byte arrives while status bit 0 is 1 is dropped. The buffer, command and length stay unchanged, and status bit 2 is set. Writing 1 to status bit 2 clears it.
- R7: A first request byte that arrives in the same cycle as a host read of address 0x02 is accepted as a new message.
- R8: Writing bit 8 = 1 with a length of 1 to 17 in bits 7:0 of address 0x01 while idle starts a reply. Status bit 1 reads 0 until the link side accepts the last byte, then returns to 1.
- R9: The reply stream sends the command at 0x03 first, then bytes 0x20, 0x21 and so on, length bytes in all. tx_last is 1 only on the final byte. tx_data is held while tx_ready is 0.
- R10: A strobe with a length of 0 or above 17 sends nothing and sets status bit 3. Writing 1 to status bit 3 clears it.
- R11: A write of address 0x01 with bit 8 = 0 starts no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Request byte valid |
| rx_data | input | 8 | Request byte |
| rx_last | input | 1 | Final byte of the request |
| rx_ready | output | 1 | Request byte accepted (always 1) |
| bus_sel | input | 1 | Host register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Final byte of the reply |
| tx_ready | input | 1 | Link side accepts the reply byte |

## Verification
Two functions can fall on the same clock edge: the host read of the command register that frees the buffer, and the first byte of the next request from the link side. The bench provokes this in one cycle by driving the read of address 0x02 together with that first byte. It then checks three things: the new message is captured, its command replaces the old one, and the overrun bit stays 0. A second case sends a request while the flag is still set, with no read, and checks that the request is dropped and counted as an overrun.

// File: rtl/sb_mailbox.sv
module sb_mailbox #(
  parameter int NB = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int IW = $clog2(NB);
  localparam int LW = $clog2(NB + 2);
  localparam logic [LW-1:0] MAXLEN = LW'(NB + 1);

  logic [7:0] rx_buf [NB];
  logic [7:0] tx_buf [NB];
  logic [7:0] rx_cmd, tx_cmd;
  logic [LW-1:0] rx_cnt, rx_len, tx_idx, tx_len;
  logic msg_ready, rx_drop, overrun, len_err, irq_en, tx_busy;

  wire wr_any  = bus_sel && bus_wr;
  wire stat_wr = wr_any && bus_addr == 6'h00;
  wire ctl_wr  = wr_any && bus_addr == 6'h01;
  wire cmd_rd  = bus_sel && !bus_wr && bus_addr == 6'h02;
  wire strobe  = bus_wdata[8];
  wire len_ok  = bus_wdata[7:0] != 8'd0 && bus_wdata[7:0] <= 8'(NB + 1);
  wire unused_wdata = ^bus_wdata[31:9];

  wire rx_first = rx_cnt == '0;
  wire drop_now = rx_first ? (msg_ready && !cmd_rd) : rx_drop;
  wire rx_done  = rx_valid && rx_last;
  wire tx_fire  = tx_valid && tx_ready;

  assign rx_ready = 1'b1;
  assign irq      = irq_en && msg_ready;
  assign tx_valid = tx_busy;
  assign tx_data  = (tx_idx == '0) ? tx_cmd : tx_buf[IW'(tx_idx - 1'b1)];
  assign tx_last  = tx_busy && tx_idx == tx_len - 1'b1;

  // receive capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt <= '0; rx_len <= '0; rx_drop <= 1'b0; rx_cmd <= '0;
      msg_ready <= 1'b0; overrun <= 1'b0;
      for (int i = 0; i < NB; i++) rx_buf[i] <= '0;
    end else begin
      if (cmd_rd) begin
        msg_ready <= 1'b0;
        rx_len <= '0;
      end
      if (stat_wr && bus_wdata[2]) overrun <= 1'b0;
      if (rx_valid) begin
        if (!drop_now && rx_cnt < MAXLEN) begin
          if (rx_first) rx_cmd <= rx_data;
          else rx_buf[IW'(rx_cnt - 1'b1)] <= rx_data;
        end
        rx_drop <= rx_last ? 1'b0 : drop_now;
        if (rx_last) rx_cnt <= '0;
        else if (rx_cnt != MAXLEN) rx_cnt <= rx_cnt + 1'b1;
        if (rx_last) begin
          if (drop_now) overrun <= 1'b1;
          else begin
            msg_ready <= 1'b1;
            rx_len <= (rx_cnt == MAXLEN) ? MAXLEN : rx_cnt + 1'b1;
          end
        end
      end
    end
  end

  // host writes and reply sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0; len_err <= 1'b0; tx_busy <= 1'b0;
      tx_idx <= '0; tx_len <= '0; tx_cmd <= '0;
      for (int i = 0; i < NB; i++) tx_buf[i] <= '0;
    end else begin
      if (stat_wr) begin
        irq_en <= bus_wdata[4];
        if (bus_wdata[3]) len_err <= 1'b0;
      end
      if (wr_any && bus_addr == 6'h03) tx_cmd <= bus_wdata[7:0];
      if (wr_any && bus_addr[5:4] == 2'b10 && 32'(bus_addr[3:0]) < NB)
        tx_buf[IW'(bus_addr[3:0])] <= bus_wdata[7:0];
      if (tx_fire) begin
        if (tx_last) tx_busy <= 1'b0;
        else tx_idx <= tx_idx + 1'b1;
      end
      if (ctl_wr && strobe && !tx_busy) begin
        if (len_ok) begin
          tx_busy <= 1'b1;
          tx_idx <= '0;
          tx_len <= LW'(bus_wdata[7:0]);
        end else len_err <= 1'b1;
      end
    end
  end

  // host read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 6'h00) begin
      bus_rdata[0] = msg_ready;
      bus_rdata[1] = !tx_busy;
      bus_rdata[2] = overrun;
      bus_rdata[3] = len_err;
      bus_rdata[4] = irq_en;
      bus_rdata[8 +: LW] = rx_len;
    end else if (bus_addr == 6'h02) bus_rdata[7:0] = rx_cmd;
    else if (bus_addr == 6'h03) bus_rdata[7:0] = tx_cmd;
    else if (bus_addr[5:4] == 2'b01 && 32'(bus_addr[3:0]) < NB)
      bus_rdata[7:0] = rx_buf[IW'(bus_addr[3:0])];
    else if (bus_addr[5:4] == 2'b10 && 32'(bus_addr[3:0]) < NB)
      bus_rdata[7:0] = tx_buf[IW'(bus_addr[3:0])];
  end

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_ready) |-> (rx_len != '0 && rx_len <= MAXLEN));
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !(rx_done && !drop_now)) |=> (!msg_ready && rx_len == '0));
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msg_ready && irq_en));
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && drop_now) |=> overrun);
  assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && tx_last && !ctl_wr) |=> !tx_valid);
  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_any) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  assert_bad_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && strobe && !tx_busy && !len_ok) |=> (len_err && !tx_valid));
endmodule

// File: tb/sb_mailbox_test.sv
module sb_mailbox_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_last = 0, bus_sel = 0, bus_wr = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rx_ready, irq, tx_valid, tx_last;
  logic [7:0] tx_data;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  sb_mailbox uut (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready));

  localparam int NV = 5;
  localparam int VSENT [NV] = '{1, 2, 17, 20, 9};
  localparam int VEXP  [NV] = '{1, 2, 17, 17, 9};
  localparam logic [7:0] VSEED [NV] = '{8'h40, 8'hA0, 8'h10, 8'h70, 8'hC5};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic send_msg(input int n, input logic [7:0] seed, input int from);
    for (int k = from; k < n; k++) begin
      @(negedge clk); rx_valid = 1; rx_data = seed + 8'(k * 7); rx_last = (k == n - 1);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic run_reply(input int len, input logic [7:0] base, input string req);
    logic [7:0] got [17];
    int n = 0, lasts = 0, cyc = 0;
    bit done = 0;
    wr_reg(6'h03, 32'(base));
    for (int i = 0; i < 16; i++) wr_reg(6'h20 + 6'(i), 32'(base + 8'(i + 1) * 8'd5));
    wr_reg(6'h01, 32'h100 | 32'(len));
    rd_reg(6'h00, rd); chk("R8 busy", 32'(rd[1]), 0);
    while (!done && cyc < 200) begin
      @(negedge clk); tx_ready = (cyc % 3 != 1); cyc++;
      #1;
      if (tx_valid && tx_ready) begin
        if (n < 17) got[n] = tx_data;
        n++;
        if (tx_last) begin lasts++; done = 1; end
      end
    end
    @(negedge clk); tx_ready = 0;
    chk({req, " count"}, 32'(n), 32'(len));
    chk({req, " last flags"}, 32'(lasts), 1);
    for (int i = 0; i < len && i < n; i++)
      chk({req, " byte"}, 32'(got[i]), (i == 0) ? 32'(base) : 32'(base + 8'(i) * 8'd5));
    chk("R8 valid low", 32'(tx_valid), 0);
    rd_reg(6'h00, rd); chk("R8 idle again", 32'(rd[1]), 1);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_reg(6'h00, rd); chk("R1 status", rd, 32'h2);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    wr_reg(6'h00, 32'h10);

    for (int v = 0; v < NV; v++) begin
      send_msg(VSENT[v], VSEED[v], 0);
      chk("R2 rx_ready", 32'(rx_ready), 1);
      rd_reg(6'h00, rd);
      chk("R2 ready", 32'(rd[0]), 1);
      chk("R2 length", 32'(rd[12:8]), 32'(VEXP[v]));
      chk("R5 irq on", 32'(irq), 1);
      for (int i = 0; i < VEXP[v] - 1; i++) begin
        rd_reg(6'h10 + 6'(i), rd);
        chk("R3 data", rd, 32'(VSEED[v] + 8'((i + 1) * 7)));
      end
      rd_reg(6'h02, rd); chk("R3 command", rd, 32'(VSEED[v]));
      rd_reg(6'h00, rd);
      chk("R4 ready cleared", 32'(rd[0]), 0);
      chk("R4 length cleared", 32'(rd[12:8]), 0);
      chk("R5 irq off", 32'(irq), 0);
    end

    // overrun
    send_msg(3, 8'h21, 0);
    send_msg(5, 8'h90, 0);
    rd_reg(6'h00, rd);
    chk("R6 overrun", 32'(rd[2]), 1);
    chk("R6 length kept", 32'(rd[12:8]), 3);
    rd_reg(6'h10, rd); chk("R6 data kept", rd, 32'(8'h21 + 8'd7));
    wr_reg(6'h00, 32'h00);
    chk("R5 disabled", 32'(irq), 0);
    wr_reg(6'h00, 32'h14);
    rd_reg(6'h00, rd); chk("R6 cleared", 32'(rd[2]), 0);
    rd_reg(6'h02, rd); chk("R6 command kept", rd, 32'h21);

    // same-cycle command read and new first byte
    send_msg(2, 8'h33, 0);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 6'h02;
    rx_valid = 1; rx_data = 8'h55; rx_last = 0;
    #1 chk("R7 old command", bus_rdata, 32'h33);
    @(negedge clk); bus_sel = 0; rx_valid = 0;
    send_msg(4, 8'h55, 1);
    rd_reg(6'h00, rd);
    chk("R7 ready", 32'(rd[0]), 1);
    chk("R7 length", 32'(rd[12:8]), 4);
    chk("R7 no overrun", 32'(rd[2]), 0);
    rd_reg(6'h02, rd); chk("R7 new command", rd, 32'h55);

    // replies
    run_reply(5, 8'h60, "R9 len5");
    run_reply(17, 8'h11, "R9 len17");
    run_reply(1, 8'hE0, "R9 len1");

    wr_reg(6'h01, 32'h100);
    chk("R10 no send len0", 32'(tx_valid), 0);
    rd_reg(6'h00, rd); chk("R10 error len0", 32'(rd[3]), 1);
    wr_reg(6'h00, 32'h18);
    rd_reg(6'h00, rd); chk("R10 error cleared", 32'(rd[3]), 0);
    wr_reg(6'h01, 32'h112);
    chk("R10 no send len18", 32'(tx_valid), 0);
    rd_reg(6'h00, rd); chk("R10 error len18", 32'(rd[3]), 1);
    wr_reg(6'h00, 32'h18);

    wr_reg(6'h01, 32'h005);
    chk("R11 no start", 32'(tx_valid), 0);
    rd_reg(6'h00, rd); chk("R11 still idle", 32'(rd[1]), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule